// File: doc/BRIEF.md
# Sign-Tracking Tally Engine with In-Place Writeback

This block walks a fixed-length window of signed words held in an external single-port memory. For every word it keeps a running tally: the tally rises by one when the word is strictly positive, and falls by one when the word is zero or negative. Straight after each update, the new tally is stored over the very word that produced it. The effect is that the window ends up holding the history of the tally, one entry per step.

A start pulse captures the window's base address and clears both the tally and the element index. The controller then repeats a fixed four-state pass for each element: read, test, then either a rise state or a fall state, then write back. The branch is taken through two separate controller states, never through a datapath select. After the last element the block raises its done flag and presents the final tally. It holds both until the next start.

Top module: `sgn_tally`

## Requirements
- R1: While reset is asserted and right after it is released, done is 0, the tally output is 0, and neither the read nor the write strobe is asserted.
- R2: A start pulse seen while idle or done clears the tally and the index and latches the base address. In the cycle after start is sampled, the read strobe is high with the address equal to that base. A change on the base input after that has no effect on the run.
- R3: One run reads exactly COUNT words, at base+0 up to base+COUNT-1, in ascending order. Each word is read once and written once.
- R4: When the word read, taken as signed two's complement, is strictly greater than zero, the tally rises by exactly one.
- R5: When the word read is zero or negative (including 0x8000), the tally falls by exactly one.
- R6: Read data is taken one cycle after the read strobe. The updated tally is written to the address just read, with the write strobe three cycles after that read strobe.
- R7: The read and write strobes are never high in the same cycle.
- R8: After the last writeback, done goes high and the tally output shows the final count. Both stay unchanged, with no memory access, until the next start.
- R9: A start pulse received while a run is in progress is ignored. The run's addresses, written values, final tally and length are unchanged.
- R10: Every element takes four cycles, whichever branch it takes. Done is first seen 4*COUNT cycles after the edge that sampled start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a run when idle or done |
| base_i | input | ADDR_W | Window base address, latched at start |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_rd_o | output | 1 | Read strobe; data returns next cycle |
| mem_wr_o | output | 1 | Write strobe; write completes this cycle |
| mem_wdata_o | output | DATA_W | Write data (updated tally) |
| mem_rdata_i | input | DATA_W | Read data, valid one cycle after the read strobe |
| done_o | output | 1 | Run finished; held until next start |
| tally_o | output | DATA_W | Running / final tally |

## Verification
Some properties are checked on every cycle. The assertions cover strobe exclusivity, the bound on the index, and a writeback landing on the address read three cycles earlier. They also check that the written value is the tally from two cycles before, moved one step in the direction set by the sign of the data returned then. Finally they check that done holds with a frozen tally and a quiet memory port.

Other behaviours only the bench scenarios can show. These are the exact ascending address sequence over a whole window, and the total run length. They also include the immunity to a start pulse or a base change in mid-run, a restart from done without reset, and the final memory image. All of these are checked against a scoreboard built from the data patterns.

// File: rtl/sgn_tally_pkg.sv
package sgn_tally_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_TEST  = 3'd2,
        ST_UP    = 3'd3,
        ST_DOWN  = 3'd4,
        ST_WRITE = 3'd5,
        ST_DONE  = 3'd6
    } tally_state_e;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_UP    = 2'd2,
        OP_DOWN  = 2'd3
    } cnt_op_e;

    typedef struct packed {
        tally_state_e state;
        logic         done;
    } ctrl_regs_t;

endpackage

// File: rtl/sgn_tally_ctrl.sv
module sgn_tally_ctrl
    import sgn_tally_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start_i,
    input  logic    is_pos_i,
    input  logic    is_last_i,
    output cnt_op_e cnt_op_o,
    output logic    idx_step_o,
    output logic    rd_o,
    output logic    wr_o,
    output logic    done_o
);

    ctrl_regs_t r_q, r_d;
    logic       accept;

    always_comb begin
        r_d        = r_q;
        cnt_op_o   = OP_HOLD;
        idx_step_o = 1'b0;
        rd_o       = 1'b0;
        wr_o       = 1'b0;
        accept     = start_i && (r_q.state == ST_IDLE || r_q.state == ST_DONE);

        unique case (r_q.state)
            ST_IDLE, ST_DONE: begin
                if (accept) begin
                    cnt_op_o  = OP_CLEAR;
                    r_d.state = ST_READ;
                    r_d.done  = 1'b0;
                end
            end
            ST_READ: begin
                rd_o      = 1'b1;
                r_d.state = ST_TEST;
            end
            ST_TEST: begin
                r_d.state = is_pos_i ? ST_UP : ST_DOWN;
            end
            ST_UP: begin
                cnt_op_o  = OP_UP;
                r_d.state = ST_WRITE;
            end
            ST_DOWN: begin
                cnt_op_o  = OP_DOWN;
                r_d.state = ST_WRITE;
            end
            ST_WRITE: begin
                wr_o = 1'b1;
                if (is_last_i) begin
                    r_d.state = ST_DONE;
                    r_d.done  = 1'b1;
                end else begin
                    idx_step_o = 1'b1;
                    r_d.state  = ST_READ;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
                r_d.done  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o = r_q.done;

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_o && wr_o)); // R7

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!rd_o && !wr_o)); // R8

endmodule

// File: rtl/sgn_tally_dp.sv
module sgn_tally_dp
    import sgn_tally_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int COUNT  = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cnt_op_e           cnt_op_i,
    input  logic              idx_step_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] cnt_o,
    output logic              is_pos_o,
    output logic              is_last_o
);

    localparam int IDX_W = (COUNT > 1) ? $clog2(COUNT) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(COUNT - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] cnt;
    } dp_regs_t;

    dp_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (cnt_op_i)
            OP_CLEAR: begin
                r_d.base = base_i;
                r_d.idx  = '0;
                r_d.cnt  = '0;
            end
            OP_UP:    r_d.cnt = r_q.cnt + DATA_W'(1);
            OP_DOWN:  r_d.cnt = r_q.cnt - DATA_W'(1);
            default:  ;
        endcase
        if (idx_step_i && r_q.idx != LAST_IDX) begin
            r_d.idx = r_q.idx + IDX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign addr_o    = r_q.base + ADDR_W'(r_q.idx);
    assign cnt_o     = r_q.cnt;
    assign is_pos_o  = !rdata_i[DATA_W-1] && (|rdata_i);
    assign is_last_o = (r_q.idx == LAST_IDX);

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.idx <= LAST_IDX); // R3

endmodule

// File: rtl/sgn_tally.sv
module sgn_tally
    import sgn_tally_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int COUNT  = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              done_o,
    output logic [DATA_W-1:0] tally_o
);

    cnt_op_e     cnt_op;
    logic        idx_step;
    logic        is_pos;
    logic        is_last;
    logic [DATA_W-1:0] cnt;

    sgn_tally_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .is_pos_i   (is_pos),
        .is_last_i  (is_last),
        .cnt_op_o   (cnt_op),
        .idx_step_o (idx_step),
        .rd_o       (mem_rd_o),
        .wr_o       (mem_wr_o),
        .done_o     (done_o)
    );

    sgn_tally_dp #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .COUNT  (COUNT)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_op_i   (cnt_op),
        .idx_step_i (idx_step),
        .base_i     (base_i),
        .rdata_i    (mem_rdata_i),
        .addr_o     (mem_addr_o),
        .cnt_o      (cnt),
        .is_pos_o   (is_pos),
        .is_last_o  (is_last)
    );

    assign mem_wdata_o = cnt;
    assign tally_o     = cnt;

    AST_WB_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> ($past(mem_rd_o, 3) && mem_addr_o == $past(mem_addr_o, 3))); // R6

    AST_RISE_ON_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && $signed($past(mem_rdata_i, 2)) > 0)
            |-> mem_wdata_o == DATA_W'($past(tally_o, 2) + DATA_W'(1))); // R4

    AST_FALL_ON_NONPOS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && $signed($past(mem_rdata_i, 2)) <= 0)
            |-> mem_wdata_o == DATA_W'($past(tally_o, 2) - DATA_W'(1))); // R5

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(tally_o))); // R8

endmodule

// File: tb/sgn_tally_test.sv
module sgn_tally_test;

    localparam int DW = 16;
    localparam int AW = 16;
    localparam int N  = 100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd, mem_wr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          done;
    logic [DW-1:0] tally;

    logic          ld_en = 1'b0;
    logic [7:0]    ld_addr = '0;
    logic [DW-1:0] ld_data = '0;
    logic [DW-1:0] mem [0:255];

    int n_chk = 0;
    int n_bad = 0;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } wr_item_t;

    wr_item_t      wr_q[$];
    logic [AW-1:0] rd_q[$];

    always #10 clk = ~clk;

    sgn_tally #(.DATA_W(DW), .ADDR_W(AW), .COUNT(N)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .base_i      (base),
        .mem_addr_o  (mem_addr),
        .mem_rd_o    (mem_rd),
        .mem_wr_o    (mem_wr),
        .mem_wdata_o (mem_wdata),
        .mem_rdata_i (mem_rdata),
        .done_o      (done),
        .tally_o     (tally)
    );

    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: pop scoreboard entries as the design accesses memory
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd) begin
                if (rd_q.size() == 0) chk(1'b0, "R3", "unexpected read", 32'(mem_addr), 0);
                else begin
                    logic [AW-1:0] ea;
                    ea = rd_q.pop_front();
                    chk(mem_addr == ea, "R3", "read address", 32'(mem_addr), 32'(ea));
                end
            end
            if (mem_wr) begin
                chk(!mem_rd, "R7", "read and write together", 32'(mem_rd), 0);
                if (wr_q.size() == 0) chk(1'b0, "R3", "unexpected write", 32'(mem_addr), 0);
                else begin
                    wr_item_t e;
                    e = wr_q.pop_front();
                    chk(mem_addr == e.a, "R6", "write address", 32'(mem_addr), 32'(e.a));
                    chk(mem_wdata == e.d, "R4", "written tally", 32'(mem_wdata), 32'(e.d));
                end
            end
        end
    end

    function automatic logic [DW-1:0] pat(input int kind, input int i);
        case (kind)
            0: pat = 16'h0000;
            1: pat = DW'(i + 1);
            2: case (i % 5)
                   0: pat = 16'h8000;
                   1: pat = 16'h7FFF;
                   2: pat = 16'h0000;
                   3: pat = 16'h0001;
                   default: pat = 16'hFFFF;
               endcase
            default: pat = DW'(i * 40503) ^ 16'h3C96;
        endcase
    endfunction

    task automatic run_case(input int kind, input logic [7:0] b, input int glitch,
                            input string treq);
        logic [DW-1:0] cnt;
        logic [DW-1:0] em [N];
        logic [DW-1:0] t0;
        int cyc;
        cnt = '0;
        for (int i = 0; i < N; i++) begin
            logic [DW-1:0] v;
            v = pat(kind, i);
            @(negedge clk);
            ld_en = 1'b1; ld_addr = b + 8'(i); ld_data = v;
            cnt = ($signed(v) > 0) ? cnt + 1'b1 : cnt - 1'b1;
            em[i] = cnt;
            rd_q.push_back(AW'(b) + AW'(i));
            wr_q.push_back({AW'(b) + AW'(i), cnt});
        end
        @(negedge clk);
        ld_en = 1'b0;
        base = AW'(b);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(mem_rd && mem_addr == AW'(b), "R2", "first read at base", 32'(mem_addr), 32'(b));
        chk(!done, "R2", "done cleared by start", 32'(done), 0);
        cyc = 0;
        while (!done && cyc < 1000) begin
            @(negedge clk);
            cyc++;
            if (glitch != 0 && cyc == glitch) begin
                start = 1'b1;
                base  = AW'(b) + 16'h0033;
            end
            if (glitch != 0 && cyc == glitch + 1) start = 1'b0;
        end
        chk(cyc == 4 * N, "R10", "cycles to done", 32'(cyc), 32'(4 * N));
        if (glitch != 0) chk(cyc == 4 * N, "R9", "mid-run start ignored", 32'(cyc), 32'(4 * N));
        chk(tally == cnt, treq, "final tally", 32'(tally), 32'(cnt));
        chk(rd_q.size() == 0 && wr_q.size() == 0, "R3", "accesses left over",
            32'(rd_q.size() + wr_q.size()), 0);
        for (int i = 0; i < N; i++) begin
            chk(mem[b + 8'(i)] == em[i], "R6", "memory image", 32'(mem[b + 8'(i)]), 32'(em[i]));
        end
        t0 = tally;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(done && tally == t0 && !mem_rd && !mem_wr, "R8", "done hold",
                {done, mem_rd, mem_wr, 13'd0, tally}, {1'b1, 2'b00, 13'd0, t0});
        end
        rd_q.delete();
        wr_q.delete();
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL R10 watchdog expired: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!done && tally == '0 && !mem_rd && !mem_wr, "R1", "state in reset",
            {done, mem_rd, mem_wr, 13'd0, tally}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && tally == '0 && !mem_rd && !mem_wr, "R1", "state after reset",
            {done, mem_rd, mem_wr, 13'd0, tally}, 0);

        run_case(0, 8'd0,   0,  "R5");  // all zeros: falls every step
        run_case(1, 8'd20,  0,  "R4");  // all positive: rises every step
        run_case(2, 8'd150, 0,  "R5");  // restart from done (R2), extremes and zero
        run_case(3, 8'd60,  57, "R9");  // mixed data with mid-run start and base change

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule